// File: doc/BRIEF.md
# Snooping Coherence Responder

This block sits next to one private cache on a shared address bus. It watches the shared-read and exclusive-read requests that other processors place on the bus and answers each one with ok or retry in the same address cycle. It also tells the local tag array how to change the line's state: Invalid, Shared or Exclusive. When the snooped line is held Exclusive, it asks the local cache-to-memory queue to take a writeback of that line.

The request type, the requester ID and the address come from the bus. The line's current state comes from a tag lookup done outside the block. The outgoing writeback queue is exposed as a valid bit and an address per slot. The response, the state-update command and the writeback-enqueue command are all combinational functions of these inputs. The clock and reset are used only to sample the block's properties. Moving data, the memory itself and bus arbitration are handled elsewhere.

Encodings: the request kind is 00 shared-read, 01 exclusive-read, 10 writeback and 11 reserved. The line state is 00 Invalid, 01 Shared, 10 Exclusive, and 11 is treated as Invalid.

Top module: `snoop_responder`

## Requirements
- R1: For a valid shared-read (kind 00) or exclusive-read (kind 01) from another requester, resp_valid_o and the response appear in the same cycle as the request, with no clock edge in between.
- R2: A request of kind writeback (10) or reserved (11) gets no response (resp_valid_o=0), no state update and no writeback enqueue.
- R3: A shared-read to a line in state Invalid (00) or 11, with no matching queued writeback, answers ok (resp_retry_o=0), with no update and no enqueue.
- R4: A shared-read to a Shared (01) line with no matching queued writeback answers ok and issues no state update.
- R5: A shared-read to an Exclusive (10) line answers retry, updates the state to Shared (01), and enqueues a writeback whose wb_addr_o equals the snooped address.
- R6: An exclusive-read to a Shared line with no matching queued writeback answers ok and updates the state to Invalid (00), with no enqueue.
- R7: An exclusive-read to an Exclusive line answers retry, updates the state to Invalid (00) and enqueues a writeback of the snooped address.
- R8: If any valid slot of the writeback queue holds the snooped address, either read kind answers retry, with no state update and no enqueue. Slots whose valid bit is low are not compared.
- R9: A request whose requester ID equals the block's own ID (parameter OWN_ID) is ignored: no response, no update, no enqueue.
- R10: An exclusive-read to an Invalid line with no matching queued writeback answers ok, with no update and no enqueue.
- R11: While snoop_valid_i is low, resp_valid_o, upd_valid_o and wb_enq_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock used to sample the block's properties |
| rst_ni | input | 1 | Active-low asynchronous reset |
| snoop_valid_i | input | 1 | A request is present on the bus in this cycle |
| snoop_kind_i | input | 2 | Request kind (00 shared-read, 01 exclusive-read, 10 writeback, 11 reserved) |
| snoop_src_i | input | IDW | ID of the requester |
| snoop_addr_i | input | AW | Line address of the request |
| line_state_i | input | 2 | Local state of the line (00 I, 01 S, 10 E, 11 treated as I) |
| wbq_valid_i | input | NQ | Valid bit of each writeback-queue slot |
| wbq_addr_i | input | NQ*AW | Addresses of the slots; slot k is at bits [k*AW +: AW] |
| resp_valid_o | output | 1 | The block is answering this request |
| resp_retry_o | output | 1 | 1 means retry, 0 means ok |
| upd_valid_o | output | 1 | Write a new state into the tag array |
| upd_state_o | output | 2 | New line state |
| wb_enq_o | output | 1 | Push a writeback into the local queue |
| wb_addr_o | output | AW | Address of the writeback (equals snoop_addr_i) |

## Verification
The hardest case to reach is a clean-looking line that must still be retried because its writeback is in flight. The bench reaches it by loading the queue so that the snooped address sits in a chosen slot, while the tag state reads Shared or Invalid. It also covers the opposite case: the matching address is placed in a slot whose valid bit is low, so a compare that wrongly ignores the valid bit turns an ok into a retry. Exclusive lines with a pending writeback are covered too, to show that the queue match takes priority over the downgrade and the second enqueue.

// File: rtl/snoop_pkg.sv
`timescale 1ns/1ps
package snoop_pkg;
  typedef enum logic [1:0] {
    SNP_SHRD = 2'b00,
    SNP_EXCL = 2'b01,
    SNP_WBK  = 2'b10,
    SNP_RSVD = 2'b11
  } snp_kind_e;

  typedef enum logic [1:0] {
    LN_INV = 2'b00,
    LN_SHR = 2'b01,
    LN_EXC = 2'b10,
    LN_BAD = 2'b11
  } line_st_e;
endpackage

// File: rtl/snp_wbq_match.sv
`timescale 1ns/1ps
module snp_wbq_match #(
  parameter int AW = 32,
  parameter int NQ = 4
) (
  input  logic [AW-1:0]    addr_i,
  input  logic [NQ-1:0]    qvalid_i,
  input  logic [NQ*AW-1:0] qaddr_i,
  output logic             hit_o
);
  logic [NQ-1:0] slot_hit;

  for (genvar k = 0; k < NQ; k++) begin : g_slot
    assign slot_hit[k] = qvalid_i[k] && (qaddr_i[k*AW +: AW] == addr_i);
  end

  assign hit_o = |slot_hit;
endmodule

// File: rtl/snp_req_filter.sv
`timescale 1ns/1ps
module snp_req_filter
  import snoop_pkg::*;
#(
  parameter int              IDW    = 3,
  parameter logic [IDW-1:0]  OWN_ID = '0
) (
  input  logic           valid_i,
  input  snp_kind_e      kind_i,
  input  logic [IDW-1:0] src_i,
  output logic           act_o,
  output logic           excl_o
);
  logic is_read;
  logic foreign;

  assign is_read = (kind_i == SNP_SHRD) || (kind_i == SNP_EXCL);
  assign foreign = (src_i != OWN_ID);
  assign act_o   = valid_i && is_read && foreign;
  assign excl_o  = (kind_i == SNP_EXCL);
endmodule

// File: rtl/snp_decide.sv
`timescale 1ns/1ps
module snp_decide
  import snoop_pkg::*;
(
  input  logic     act_i,
  input  logic     excl_i,
  input  line_st_e state_i,
  input  logic     hit_i,
  output logic     retry_o,
  output logic     upd_valid_o,
  output line_st_e upd_state_o,
  output logic     enq_o
);
  always_comb begin
    retry_o     = 1'b0;
    upd_valid_o = 1'b0;
    upd_state_o = LN_INV;
    enq_o       = 1'b0;
    if (act_i) begin
      if (hit_i) begin
        // pending writeback wins over any state action
        retry_o = 1'b1;
      end else begin
        case (state_i)
          LN_EXC: begin
            retry_o     = 1'b1;
            upd_valid_o = 1'b1;
            upd_state_o = excl_i ? LN_INV : LN_SHR;
            enq_o       = 1'b1;
          end
          LN_SHR: begin
            if (excl_i) begin
              upd_valid_o = 1'b1;
              upd_state_o = LN_INV;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/snoop_responder.sv
`timescale 1ns/1ps
module snoop_responder
  import snoop_pkg::*;
#(
  parameter int             AW     = 32,
  parameter int             NQ     = 4,
  parameter int             IDW    = 3,
  parameter logic [IDW-1:0] OWN_ID = 3'd5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             snoop_valid_i,
  input  logic [1:0]       snoop_kind_i,
  input  logic [IDW-1:0]   snoop_src_i,
  input  logic [AW-1:0]    snoop_addr_i,
  input  logic [1:0]       line_state_i,
  input  logic [NQ-1:0]    wbq_valid_i,
  input  logic [NQ*AW-1:0] wbq_addr_i,
  output logic             resp_valid_o,
  output logic             resp_retry_o,
  output logic             upd_valid_o,
  output logic [1:0]       upd_state_o,
  output logic             wb_enq_o,
  output logic [AW-1:0]    wb_addr_o
);
  snp_kind_e kind;
  line_st_e  cur_st;
  line_st_e  nxt_st;
  logic      act;
  logic      excl;
  logic      q_hit;

  assign kind   = snp_kind_e'(snoop_kind_i);
  assign cur_st = line_st_e'(line_state_i);

  snp_req_filter #(.IDW(IDW), .OWN_ID(OWN_ID)) u_filter (
    .valid_i (snoop_valid_i),
    .kind_i  (kind),
    .src_i   (snoop_src_i),
    .act_o   (act),
    .excl_o  (excl)
  );

  snp_wbq_match #(.AW(AW), .NQ(NQ)) u_match (
    .addr_i   (snoop_addr_i),
    .qvalid_i (wbq_valid_i),
    .qaddr_i  (wbq_addr_i),
    .hit_o    (q_hit)
  );

  snp_decide u_decide (
    .act_i       (act),
    .excl_i      (excl),
    .state_i     (cur_st),
    .hit_i       (q_hit),
    .retry_o     (resp_retry_o),
    .upd_valid_o (upd_valid_o),
    .upd_state_o (nxt_st),
    .enq_o       (wb_enq_o)
  );

  assign resp_valid_o = act;
  assign upd_state_o  = nxt_st;
  assign wb_addr_o    = snoop_addr_i;

  AST_WBK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snoop_valid_i && snoop_kind_i[1]) |-> (!resp_valid_o && !upd_valid_o && !wb_enq_o)); // R2
  AST_OWN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snoop_valid_i && snoop_src_i == OWN_ID) |-> (!resp_valid_o && !upd_valid_o && !wb_enq_o)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snoop_valid_i |-> (!resp_valid_o && !upd_valid_o && !wb_enq_o)); // R11
  AST_HIT_RETRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && q_hit) |-> (resp_retry_o && !upd_valid_o && !wb_enq_o)); // R8
  AST_ENQ_RETRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_enq_o |-> (resp_valid_o && resp_retry_o && upd_valid_o)); // R5
  AST_UPD_NOT_EXC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_o |-> (upd_state_o != 2'b10)); // R7
  AST_OK_NO_ENQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_retry_o) |-> !wb_enq_o); // R6
  AST_READ_ANSWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snoop_valid_i && !snoop_kind_i[1] && snoop_src_i != OWN_ID) |-> resp_valid_o); // R1
endmodule

// File: tb/snoop_responder_test.sv
`timescale 1ns/1ps
module snoop_responder_test;
  localparam int AW  = 32;
  localparam int NQ  = 4;
  localparam int IDW = 3;
  localparam int NV  = 16;
  localparam int VW  = 57;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             snoop_valid_i = 1'b0;
  logic [1:0]       snoop_kind_i = '0;
  logic [IDW-1:0]   snoop_src_i = '0;
  logic [AW-1:0]    snoop_addr_i = '0;
  logic [1:0]       line_state_i = '0;
  logic [NQ-1:0]    wbq_valid_i = '0;
  logic [NQ*AW-1:0] wbq_addr_i = '0;
  logic             resp_valid_o, resp_retry_o, upd_valid_o, wb_enq_o;
  logic [1:0]       upd_state_o;
  logic [AW-1:0]    wb_addr_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  snoop_responder #(.AW(AW), .NQ(NQ), .IDW(IDW), .OWN_ID(3'd5)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .snoop_valid_i(snoop_valid_i), .snoop_kind_i(snoop_kind_i),
    .snoop_src_i(snoop_src_i), .snoop_addr_i(snoop_addr_i),
    .line_state_i(line_state_i), .wbq_valid_i(wbq_valid_i), .wbq_addr_i(wbq_addr_i),
    .resp_valid_o(resp_valid_o), .resp_retry_o(resp_retry_o),
    .upd_valid_o(upd_valid_o), .upd_state_o(upd_state_o),
    .wb_enq_o(wb_enq_o), .wb_addr_o(wb_addr_o)
  );

  // {req, valid, kind, src, state, qvalid, hit_en, hit_slot, addr, rv, rr, uv, us, we}
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd3,  1'b1, 2'b00, 3'd1, 2'b00, 4'b0000, 1'b0, 2'd0, 32'h0000_1040, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0}, // R3
    {4'd4,  1'b1, 2'b00, 3'd2, 2'b01, 4'b1111, 1'b0, 2'd0, 32'h0000_2080, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0}, // R4
    {4'd5,  1'b1, 2'b00, 3'd0, 2'b10, 4'b0011, 1'b0, 2'd0, 32'hA5A5_0000, 1'b1, 1'b1, 1'b1, 2'b01, 1'b1}, // R5
    {4'd6,  1'b1, 2'b01, 3'd7, 2'b01, 4'b0101, 1'b0, 2'd0, 32'h0000_30C0, 1'b1, 1'b0, 1'b1, 2'b00, 1'b0}, // R6
    {4'd7,  1'b1, 2'b01, 3'd3, 2'b10, 4'b0000, 1'b0, 2'd0, 32'hDEAD_BE00, 1'b1, 1'b1, 1'b1, 2'b00, 1'b1}, // R7
    {4'd10, 1'b1, 2'b01, 3'd4, 2'b00, 4'b1010, 1'b0, 2'd0, 32'h0000_4100, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0}, // R10
    {4'd8,  1'b1, 2'b00, 3'd1, 2'b01, 4'b0100, 1'b1, 2'd2, 32'h0000_5140, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0}, // R8
    {4'd8,  1'b1, 2'b01, 3'd2, 2'b01, 4'b1000, 1'b1, 2'd3, 32'h0000_6180, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0}, // R8
    {4'd8,  1'b1, 2'b00, 3'd6, 2'b00, 4'b0001, 1'b1, 2'd0, 32'h0000_71C0, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0}, // R8
    {4'd8,  1'b1, 2'b00, 3'd6, 2'b01, 4'b1011, 1'b1, 2'd2, 32'h0000_8200, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0}, // R8 invalid slot
    {4'd8,  1'b1, 2'b01, 3'd0, 2'b10, 4'b0010, 1'b1, 2'd1, 32'h0000_9240, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0}, // R8 over E
    {4'd2,  1'b1, 2'b10, 3'd1, 2'b10, 4'b0000, 1'b0, 2'd0, 32'h0000_A280, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0}, // R2
    {4'd2,  1'b1, 2'b11, 3'd1, 2'b10, 4'b0000, 1'b0, 2'd0, 32'h0000_B2C0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0}, // R2 reserved
    {4'd9,  1'b1, 2'b00, 3'd5, 2'b10, 4'b0000, 1'b0, 2'd0, 32'h0000_C300, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0}, // R9
    {4'd11, 1'b0, 2'b01, 3'd1, 2'b10, 4'b0000, 1'b0, 2'd0, 32'h0000_D340, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0}, // R11
    {4'd3,  1'b1, 2'b00, 3'd1, 2'b11, 4'b0000, 1'b0, 2'd0, 32'h0000_E380, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0}  // R3 state 11
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_vec(input logic [VW-1:0] v);
    snoop_valid_i = v[52];
    snoop_kind_i  = v[51:50];
    snoop_src_i   = v[49:47];
    line_state_i  = v[46:45];
    wbq_valid_i   = v[44:41];
    snoop_addr_i  = v[37:6];
    for (int j = 0; j < NQ; j++)
      wbq_addr_i[j*AW +: AW] = (v[40] && v[39:38] == j[1:0]) ? v[37:6] : (v[37:6] ^ (32'h100 << j));
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R11 reset state with idle bus
    repeat (3) @(negedge clk);
    #1 check("R11", {61'd0, resp_valid_o, upd_valid_o, wb_enq_o}, 64'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive_vec(VEC[i]);
      #1;
      check($sformatf("R%0d vec%0d", VEC[i][56:53], i),
            {58'd0, resp_valid_o, resp_retry_o, upd_valid_o, upd_state_o, wb_enq_o},
            {58'd0, VEC[i][5:0]});
      if (VEC[i][0]) check("R5/R7 wb_addr", {32'd0, wb_addr_o}, {32'd0, VEC[i][37:6]});
    end

    // R1: mid-cycle change of request answered before the next edge
    @(negedge clk);
    drive_vec(VEC[0]);
    #0.5 check("R1 first", {62'd0, resp_valid_o, resp_retry_o}, 64'b10);
    drive_vec(VEC[4]);
    #0.5 check("R1 second", {62'd0, resp_valid_o, resp_retry_o}, 64'b11);

    // R5 then R4: line downgraded, the queue now holds its writeback, next snoop retried
    @(negedge clk);
    drive_vec(VEC[2]);
    #1 check("R5 downgrade", {61'd0, upd_valid_o, upd_state_o}, {61'd0, 3'b101});
    @(negedge clk);
    line_state_i = 2'b01;
    wbq_valid_i = 4'b0001;
    wbq_addr_i[AW-1:0] = snoop_addr_i;
    #1 check("R8 after enqueue", {61'd0, resp_retry_o, upd_valid_o, wb_enq_o}, {61'd0, 3'b100});

    // R11 idle again
    @(negedge clk);
    snoop_valid_i = 1'b0;
    #1 check("R11 idle", {61'd0, resp_valid_o, upd_valid_o, wb_enq_o}, 64'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule